// File: doc/BRIEF.md
# Serial Stereo Audio Transmitter

This block turns pairs of parallel 16-bit two's complement audio samples (one left, one right) into a three-wire serial stream: a bit clock, a frame clock that marks the channel, and a data line. It runs from a system clock at 384 times the sample rate and makes both output clocks itself. It has no clock input for the serial side, so a downstream receiver only needs the three outputs.

A frame lasts 48 bit clocks and is split into two halves of 24 bit positions each. The left half comes first, and the frame clock is high while it is sent. In each half the first 8 positions are padding and are driven to zero. The 16-bit word follows in the last 16 positions, most significant bit first. The host presents a new sample pair and pulses a load strobe at any time in a frame. The pair waits in holding registers and is moved into the shift path at the next frame boundary, so a frame that is already being sent is never disturbed. All three outputs come straight from flip-flops and change together on the falling bit-clock edge, so a receiver can sample on the rising edge.

Top module: `stereo_serial_tx`

## Requirements
- R1: While reset is high, the bit clock, frame clock and data outputs are all 0, and the holding registers are cleared to zero. A frame sent after reset with no load carries all-zero words.
- R2: The bit clock is the system clock divided by 8. It is high for exactly 4 system clocks and low for exactly 4 system clocks.
- R3: A frame is 48 bit clocks (384 system clocks). The frame clock is 1 for the first 24 bit positions (left half) and 0 for the last 24 (right half).
- R4: The frame clock and data outputs change only in the same system clock cycle in which the bit clock falls.
- R5: Positions 0 to 7 of each half (frame positions 0–7 and 24–31) carry data 0.
- R6: The left word is sent in frame positions 8 to 23 and the right word in positions 32 to 47. Each word goes most significant bit first, so position 8 carries left bit 15 and position 47 carries right bit 0.
- R7: A high load strobe on a rising system clock edge captures both input words. The captured pair is sent from the next frame start on. If several loads happen before a frame start, the last one is sent.
- R8: A load that occurs while a frame is being sent does not change any bit of that frame.
- R9: After reset is released, the frame clock rises on the 8th rising system clock edge, together with the first falling edge of the bit clock. That edge starts frame position 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, 384 times the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Strobe that captures left_i and right_i |
| left_i | input | 16 | Left sample, two's complement |
| right_i | input | 16 | Right sample, two's complement |
| bck_o | output | 1 | Serial bit clock, clk/8, 50 % duty |
| lrclk_o | output | 1 | Frame clock, high during the left half |
| sdata_o | output | 1 | Serial data, changes on the falling bit-clock edge |

## Verification
The sample pairs are chosen so that different faults give different results. A full-scale negative left against a full-scale positive right exposes any mix-up of the channels or of the sign bit. All-ones against all-zeros exposes leakage into the padding positions. Alternating patterns (A5A5/5A5A) catch off-by-one shifting and a reversed bit order. Words with only the LSB, or only the MSB and LSB, set catch a lost first or last bit. Directed cases load a new pair in the middle of a frame, load twice before one boundary, and reset in the middle of a run. These separate "held until the next frame" from "taken at once", and "last load wins" from "first load wins".

// File: rtl/ser_pkg.sv
`timescale 1ns/1ps
package ser_pkg;

    // System clocks per output bit clock, word width and zero padding per half
    localparam int unsigned SYS_PER_BIT = 8;
    localparam int unsigned WORD_BITS   = 16;
    localparam int unsigned PAD_BITS    = 8;

    typedef enum logic {
        HALF_LEFT  = 1'b0,
        HALF_RIGHT = 1'b1
    } half_e;

    // One-cycle strobes that mark the bit-clock edges to be produced
    typedef struct packed {
        logic rise;
        logic fall;
    } bck_evt_t;

    function automatic half_e other_half(input half_e h);
        return (h == HALF_LEFT) ? HALF_RIGHT : HALF_LEFT;
    endfunction

endpackage

// File: rtl/ser_bitclk.sv
`timescale 1ns/1ps
module ser_bitclk
    import ser_pkg::*;
#(
    parameter int unsigned DIV = SYS_PER_BIT
) (
    input  logic     clk,
    input  logic     rst,
    output bck_evt_t evt,
    output logic     bck_o
);
    localparam int unsigned CW    = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int unsigned HALFP = DIV / 2;
    localparam int unsigned RW    = $clog2(DIV + 2);

    logic [CW-1:0] div_cnt;

    always_comb begin
        evt.rise = (div_cnt == CW'(HALFP - 1));
        evt.fall = (div_cnt == CW'(DIV - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt <= '0;
            bck_o   <= 1'b0;
        end else begin
            div_cnt <= evt.fall ? '0 : div_cnt + 1'b1;
            if (evt.rise)
                bck_o <= 1'b1;
            else if (evt.fall)
                bck_o <= 1'b0;
        end
    end

    // Run-length check on the produced bit clock
    logic          bck_d;
    logic [RW-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            bck_d   <= 1'b0;
            run_len <= '0;
        end else begin
            bck_d <= bck_o;
            if (bck_o != bck_d)
                run_len <= RW'(1);
            else if (run_len <= RW'(HALFP))
                run_len <= run_len + 1'b1;
        end
    end

    assert_bck_phase_R2: assert property (@(posedge clk) disable iff (rst)
        run_len <= RW'(HALFP))
        else $error("bit clock phase longer than half period");

    initial begin
        assert_div_even_R2: assert ((DIV % 2) == 0 && DIV >= 2)
            else $error("divider must be even");
    end

endmodule

// File: rtl/ser_slotctr.sv
`timescale 1ns/1ps
module ser_slotctr
    import ser_pkg::*;
#(
    parameter int unsigned HALF_SLOTS = WORD_BITS + PAD_BITS,
    parameter int unsigned IDX_W      = $clog2(HALF_SLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fall,
    output half_e            cur_half,
    output logic [IDX_W-1:0] cur_idx,
    output half_e            nxt_half,
    output logic [IDX_W-1:0] nxt_idx,
    output logic             frame_start
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HALF_SLOTS - 1);

    always_comb begin
        if (cur_idx == LAST_IDX) begin
            nxt_idx  = '0;
            nxt_half = other_half(cur_half);
        end else begin
            nxt_idx  = cur_idx + 1'b1;
            nxt_half = cur_half;
        end
        frame_start = fall && (nxt_idx == '0) && (nxt_half == HALF_LEFT);
    end

    // Reset parks the counter on the last position so the first fall starts a frame
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_half <= HALF_RIGHT;
            cur_idx  <= LAST_IDX;
        end else if (fall) begin
            cur_half <= nxt_half;
            cur_idx  <= nxt_idx;
        end
    end

    assert_idx_range_R3: assert property (@(posedge clk) disable iff (rst)
        fall && (cur_idx == LAST_IDX) |=> (cur_idx == '0) && (cur_half != $past(cur_half)))
        else $error("half boundary not taken after last position");

endmodule

// File: rtl/ser_hold.sv
`timescale 1ns/1ps
module ser_hold
    import ser_pkg::*;
#(
    parameter int unsigned W = WORD_BITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] left_in,
    input  logic [W-1:0] right_in,
    output logic [W-1:0] held_l,
    output logic [W-1:0] held_r
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held_l <= '0;
            held_r <= '0;
        end else if (load) begin
            held_l <= left_in;
            held_r <= right_in;
        end
    end

    assert_hold_capture_R7: assert property (@(posedge clk) disable iff (rst)
        load |=> (held_l == $past(left_in)) && (held_r == $past(right_in)))
        else $error("holding registers missed a load");

endmodule

// File: rtl/ser_shifter.sv
`timescale 1ns/1ps
module ser_shifter
    import ser_pkg::*;
#(
    parameter int unsigned W     = WORD_BITS,
    parameter int unsigned PAD   = PAD_BITS,
    parameter int unsigned IDX_W = $clog2(W + PAD)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fall,
    input  logic             frame_start,
    input  half_e            nxt_half,
    input  logic [IDX_W-1:0] nxt_idx,
    input  logic [W-1:0]     held_l,
    input  logic [W-1:0]     held_r,
    output logic             sdata_o,
    output logic             lrclk_o
);
    localparam int unsigned SW = 2 * W;

    logic [SW-1:0] shreg;
    logic          data_pos;

    always_comb data_pos = (nxt_idx >= IDX_W'(PAD));

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            sdata_o <= 1'b0;
            lrclk_o <= 1'b0;
        end else if (fall) begin
            lrclk_o <= (nxt_half == HALF_LEFT);
            if (frame_start) begin
                shreg   <= {held_l, held_r};
                sdata_o <= 1'b0;
            end else if (data_pos) begin
                sdata_o <= shreg[SW-1];
                shreg   <= {shreg[SW-2:0], 1'b0};
            end else begin
                sdata_o <= 1'b0;
            end
        end
    end

    assert_frame_load_R7: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> shreg == $past({held_l, held_r}))
        else $error("shift path not loaded at frame start");

    assert_pad_keeps_shreg_R8: assert property (@(posedge clk) disable iff (rst)
        (fall && !frame_start && !data_pos) |=> $stable(shreg))
        else $error("shift path moved during padding");

    initial begin
        assert_pad_nonzero_R5: assert (PAD >= 1)
            else $error("at least one padding position needed");
    end

endmodule

// File: rtl/stereo_serial_tx.sv
`timescale 1ns/1ps
module stereo_serial_tx
    import ser_pkg::*;
#(
    parameter int unsigned DIV  = SYS_PER_BIT,
    parameter int unsigned W    = WORD_BITS,
    parameter int unsigned PAD  = PAD_BITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] left_i,
    input  logic [W-1:0] right_i,
    output logic         bck_o,
    output logic         lrclk_o,
    output logic         sdata_o
);
    localparam int unsigned HALF_SLOTS = W + PAD;
    localparam int unsigned IDX_W      = $clog2(HALF_SLOTS);

    bck_evt_t         evt;
    half_e            cur_half, nxt_half;
    logic [IDX_W-1:0] cur_idx, nxt_idx;
    logic             frame_start;
    logic [W-1:0]     held_l, held_r;

    ser_bitclk #(.DIV(DIV)) u_bitclk (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .bck_o (bck_o)
    );

    ser_slotctr #(.HALF_SLOTS(HALF_SLOTS), .IDX_W(IDX_W)) u_slot (
        .clk         (clk),
        .rst         (rst),
        .fall        (evt.fall),
        .cur_half    (cur_half),
        .cur_idx     (cur_idx),
        .nxt_half    (nxt_half),
        .nxt_idx     (nxt_idx),
        .frame_start (frame_start)
    );

    ser_hold #(.W(W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .load     (load_i),
        .left_in  (left_i),
        .right_in (right_i),
        .held_l   (held_l),
        .held_r   (held_r)
    );

    ser_shifter #(.W(W), .PAD(PAD), .IDX_W(IDX_W)) u_shift (
        .clk         (clk),
        .rst         (rst),
        .fall        (evt.fall),
        .frame_start (frame_start),
        .nxt_half    (nxt_half),
        .nxt_idx     (nxt_idx),
        .held_l      (held_l),
        .held_r      (held_r),
        .sdata_o     (sdata_o),
        .lrclk_o     (lrclk_o)
    );

    assert_edge_align_R4: assert property (@(posedge clk) disable iff (rst)
        (!$stable(lrclk_o) || !$stable(sdata_o)) |-> $fell(bck_o))
        else $error("output changed away from falling bit clock");

    assert_lrclk_half_R3: assert property (@(posedge clk) disable iff (rst)
        lrclk_o == (cur_half == HALF_LEFT))
        else $error("frame clock disagrees with current half");

    assert_pad_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (cur_idx < IDX_W'(PAD)) |-> !sdata_o)
        else $error("data in padding position");

endmodule

// File: tb/stereo_serial_tx_tb.sv
`timescale 1ns/1ps
module stereo_serial_tx_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_i = 1'b0;
    logic [15:0] left_i = '0;
    logic [15:0] right_i = '0;
    logic        bck_o, lrclk_o, sdata_o;

    int n_checks = 0;
    int n_fail   = 0;
    int align_err = 0;
    bit finished = 0;

    logic [15:0] poke_l, poke_r;

    always #2 clk = ~clk;

    stereo_serial_tx u_dut (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load_i),
        .left_i  (left_i),
        .right_i (right_i),
        .bck_o   (bck_o),
        .lrclk_o (lrclk_o),
        .sdata_o (sdata_o)
    );

    // Stimulus: {left, right}
    localparam logic [31:0] VEC [6] = '{
        32'h8000_7FFF,
        32'hFFFF_0000,
        32'hA5A5_5A5A,
        32'h0001_8001,
        32'h1234_FEDC,
        32'h0000_FFFF
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // R4 monitor: outputs may change only when the bit clock falls
    logic p_bck, p_ws, p_sd, p_rst;
    always @(negedge clk) begin
        if (!rst && !p_rst && ((sdata_o !== p_sd) || (lrclk_o !== p_ws))
            && !(p_bck === 1'b1 && bck_o === 1'b0))
            align_err++;
        p_bck = bck_o; p_ws = lrclk_o; p_sd = sdata_o; p_rst = rst;
    end

    task automatic pulse_load(input logic [15:0] l, input logic [15:0] r);
        left_i = l; right_i = r; load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    // Capture the next whole frame as a receiver would (on bit-clock rise)
    task automatic capture(input int poke_slot, output logic [15:0] l,
                           output logic [15:0] r, output int pad_bad, output int ws_bad);
        logic pw, pb;
        int slot;
        l = '0; r = '0; pad_bad = 0; ws_bad = 0;
        pw = lrclk_o;
        forever begin
            @(negedge clk);
            if (lrclk_o && !pw) break;
            pw = lrclk_o;
        end
        slot = 0;
        pb = bck_o;
        while (slot < 48) begin
            @(negedge clk);
            load_i = 1'b0;
            if (bck_o && !pb) begin
                if ((slot % 24) < 8) begin
                    if (sdata_o !== 1'b0) pad_bad++;
                end else if (slot < 24) begin
                    l[23 - slot] = sdata_o;
                end else begin
                    r[47 - slot] = sdata_o;
                end
                if (lrclk_o !== (slot < 24)) ws_bad++;
                if (slot == poke_slot) begin
                    left_i = poke_l; right_i = poke_r; load_i = 1'b1;
                end
                slot++;
            end
            pb = bck_o;
        end
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic check_frame(input string tag, input logic [15:0] el, input logic [15:0] er,
                               input logic [15:0] l, input logic [15:0] r, input int pb, input int wb);
        check(l == el, "R6", {tag, " left word"}, {16'h0, l}, {16'h0, el});
        check(r == er, "R6", {tag, " right word"}, {16'h0, r}, {16'h0, er});
        check(pb == 0, "R5", {tag, " padding zero"}, pb, 0);
        check(wb == 0, "R3", {tag, " frame clock halves"}, wb, 0);
    endtask

    initial begin
        logic [15:0] l, r;
        int pb, wb, cnt;

        // R1: reset state
        repeat (5) @(negedge clk);
        check(bck_o == 0, "R1", "bck in reset", bck_o, 0);
        check(lrclk_o == 0, "R1", "lrclk in reset", lrclk_o, 0);
        check(sdata_o == 0, "R1", "sdata in reset", sdata_o, 0);

        // R9: frame clock rises on the 8th edge after release
        rst = 1'b0;
        cnt = 0;
        for (int i = 1; i <= 20; i++) begin
            @(negedge clk);
            if (lrclk_o && cnt == 0) cnt = i;
        end
        check(cnt == 8, "R9", "first frame edge", cnt, 8);

        // R1: cleared holding registers give a zero frame
        capture(-1, l, r, pb, wb);
        check_frame("R1 post-reset", 16'h0, 16'h0, l, r, pb, wb);

        // R2: bit clock 4 high, 4 low
        begin
            int hi, per;
            hi = 0; per = 0;
            @(posedge bck_o); @(negedge clk);
            while (bck_o) begin @(negedge clk); hi++; end
            per = hi;
            while (!bck_o) begin @(negedge clk); per++; end
            check(hi == 4, "R2", "bck high length", hi, 4);
            check(per == 8, "R2", "bck period", per, 8);
        end

        // R3: frame length 384 system clocks
        begin
            int len;
            @(posedge lrclk_o); @(negedge clk);
            len = 0;
            while (lrclk_o) begin @(negedge clk); len++; end
            while (!lrclk_o) begin @(negedge clk); len++; end
            check(len == 384, "R3", "frame period", len, 384);
        end

        // Table of sample pairs (R6, R5, R3, R7)
        foreach (VEC[i]) begin
            pulse_load(VEC[i][31:16], VEC[i][15:0]);
            capture(-1, l, r, pb, wb);
            check_frame($sformatf("vec%0d", i), VEC[i][31:16], VEC[i][15:0], l, r, pb, wb);
        end

        // R8: load in the left word, then in the right padding; frame unchanged
        pulse_load(16'h1357, 16'h2468);
        poke_l = 16'hDEAD; poke_r = 16'hBEEF;
        capture(10, l, r, pb, wb);
        check(l == 16'h1357 && r == 16'h2468, "R8", "mid-frame load (left)", {l, r}, 32'h1357_2468);
        capture(-1, l, r, pb, wb);
        check(l == 16'hDEAD && r == 16'hBEEF, "R7", "load taken at next frame", {l, r}, 32'hDEAD_BEEF);
        poke_l = 16'h0F0F; poke_r = 16'hF0F0;
        capture(27, l, r, pb, wb);
        check(l == 16'hDEAD && r == 16'hBEEF, "R8", "mid-frame load (right)", {l, r}, 32'hDEAD_BEEF);

        // R7: last of two loads wins
        pulse_load(16'h1111, 16'h2222);
        pulse_load(16'h4C4C, 16'hC4C4);
        capture(-1, l, r, pb, wb);
        check(l == 16'h4C4C && r == 16'hC4C4, "R7", "last load wins", {l, r}, 32'h4C4C_C4C4);

        // R1: reset mid-run clears outputs and held data
        repeat (37) @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check({bck_o, lrclk_o, sdata_o} == 3'b000, "R1", "outputs after mid-run reset",
              {29'h0, bck_o, lrclk_o, sdata_o}, 0);
        rst = 1'b0;
        capture(-1, l, r, pb, wb);
        check(l == 0 && r == 0, "R1", "held data cleared", {l, r}, 0);

        check(align_err == 0, "R4", "output changes only at bck fall", align_err, 0);

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(400_000);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule